// File: doc/BRIEF.md
# Fetch Halfword Aligner

This block sits between a fetch latch and an instruction cache. It serves several thread groups. It turns program counters on 2-byte boundaries into word-aligned cache requests. It then rebuilds instructions from the returned cache lines. Each cache line holds several 32-bit words. The block picks the word that was requested and then selects the halfword at the PC. It emits one of two results: a 16-bit compressed instruction, zero-extended, or a full 32-bit instruction. The low two bits of the halfword decide which.

A 32-bit instruction can start on the upper halfword of a word. In that case the instruction continues into the next word. The block keeps the first half in per-group storage and produces no output for that response. It then queues a second fetch of the next word in a small first-in first-out refetch queue. Queued second fetches always go to the cache ahead of new requests. When the second response arrives, the two halves are joined and emitted.

Each group has at most one request in flight. Both requests and responses carry the group number. Results leave through a valid/ready port. The cache response is consumed only in the cycle the result port accepts it.

Top module: `fetch_aligner`

## Requirements
- R1: A new request is sent to the cache at its PC with bits [1:0] forced to zero, tagged with the requesting group.
- R2: While a second fetch is queued, the cache request shows the oldest queued group at (its saved PC with bits [1:0] zeroed) + 4, and `req_ready` is 0; a new request is accepted only when the queue is empty and `ic_req_ready` is 1.
- R3: The 32-bit word used is the one at byte offset (fetch address mod LINE_BYTES) of the returned line, where line byte k occupies bits [8k+7:8k]; this includes a second fetch that lands in the next line.
- R4: With no second fetch pending, the halfword is word bits [31:16] when PC[1]=1 and bits [15:0] when PC[1]=0; if its bits [1:0] are not 2'b11 the result is that halfword zero-extended to 32 bits.
- R5: If the halfword's bits [1:0] are 2'b11 and PC[1]=0, the result is the whole fetched word.
- R6: If the halfword's bits [1:0] are 2'b11 and PC[1]=1, the response produces no output, the word's upper 16 bits are kept, and the group enters the refetch queue.
- R7: The response to a second fetch produces {new word bits [15:0], kept upper half}, after which the group's pending state is cleared.
- R8: After reset no cache request is issued without an incoming request, no output is valid, and the refetch queue is empty.
- R9: Queued second fetches leave the queue in the order their first responses arrived.
- R10: `ic_rsp_ready` follows `out_ready`; while `out_ready` is 0 a pending result stays valid and unchanged and is not consumed.
- R11: Every result carries the group number of its response and the PC at which the instruction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New fetch request present |
| req_ready | output | 1 | New fetch request accepted this cycle |
| req_gid | input | GID_W | Group of the new request |
| req_pc | input | ADDR_W | PC of the new request (2-byte aligned) |
| ic_req_valid | output | 1 | Cache request present |
| ic_req_ready | input | 1 | Cache takes the request |
| ic_req_gid | output | GID_W | Group tag on the cache request |
| ic_req_addr | output | ADDR_W | Word-aligned cache address |
| ic_rsp_valid | input | 1 | Cache response present |
| ic_rsp_ready | output | 1 | Response consumed this cycle |
| ic_rsp_gid | input | GID_W | Group tag on the response |
| ic_rsp_line | input | LINE_BYTES*8 | Returned cache line |
| out_valid | output | 1 | Instruction result present |
| out_ready | input | 1 | Downstream takes the result |
| out_gid | output | GID_W | Group of the result |
| out_pc | output | ADDR_W | Starting PC of the instruction |
| out_instr | output | 32 | Zero-extended compressed or full 32-bit instruction |

## Verification
The directed tests cover both halfword positions for compressed and 32-bit instructions, words at different offsets within a line, and a split instruction whose second half lies in the next cache line. Each of these is a corner where a wrong offset or a wrong half gives a visibly wrong instruction. Two further tests stall the cache while second fetches are queued. One of them keeps a new request waiting, so a design that lets new requests pass queued refetches shows the wrong address order. The other queues two groups, so a queue that reorders its entries swaps the second-fetch addresses. A stalled result port checks that a response is held rather than dropped or consumed twice. A design that emitted a partial result for the first half of a split instruction would show one extra output.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int FA_HALF_W  = 16;
    localparam int FA_INSTR_W = 32;

    // How the current cache response is used
    typedef enum logic [1:0] {
        RK_SHORT = 2'd0,  // compressed halfword, emitted zero-extended
        RK_FULL  = 2'd1,  // aligned 32-bit word, emitted as is
        RK_HEAD  = 2'd2,  // first half of a split instruction, nothing emitted
        RK_TAIL  = 2'd3   // second half arrives, joined result emitted
    } rsp_kind_e;

    function automatic logic fa_is_short(input logic [FA_HALF_W-1:0] half);
        return half[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/fa_refetch_fifo.sv
module fa_refetch_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t       ctl_q, ctl_d;
    logic [W-1:0] slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        if (push) ctl_d.wr = ptr_next(ctl_q.wr);
        if (pop)  ctl_d.rd = ptr_next(ctl_q.rd);
        unique case ({push, pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            2'b01:   ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
        if (push) slot_q[ctl_q.wr] <= push_data;
    end

    assign head  = slot_q[ctl_q.rd];
    assign count = ctl_q.cnt;

endmodule

// File: rtl/fa_line_word.sv
// Picks one 32-bit word out of a cache line. LINE_BYTES is a power of two, at least 8.
module fa_line_word #(
    parameter int LINE_BYTES = 16,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORDS  = LINE_BYTES / 4,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic [LINE_W-1:0] line,
    input  logic [IDX_W-1:0]  idx,
    output logic [31:0]       word
);

    logic [31:0] slot [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        assign slot[w] = line[w*32 +: 32];
    end

    assign word = slot[idx];

endmodule

// File: rtl/fa_half_align.sv
module fa_half_align
    import fa_pkg::*;
(
    input  logic                  pc_hi,     // PC bit 1
    input  logic                  need2,     // second half awaited
    input  logic [FA_HALF_W-1:0]  kept_low,
    input  logic [31:0]           word,
    output rsp_kind_e             kind,
    output logic [FA_INSTR_W-1:0] instr
);

    logic [FA_HALF_W-1:0] half;

    assign half = pc_hi ? word[31:16] : word[15:0];

    always_comb begin
        if (need2) begin
            kind  = RK_TAIL;
            instr = {word[15:0], kept_low};
        end else if (fa_is_short(half)) begin
            kind  = RK_SHORT;
            instr = {{(FA_INSTR_W-FA_HALF_W){1'b0}}, half};
        end else if (!pc_hi) begin
            kind  = RK_FULL;
            instr = word;
        end else begin
            kind  = RK_HEAD;
            instr = '0;
        end
    end

endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int NUM_GRP    = 4,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    localparam int GID_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [GID_W-1:0]  req_gid,
    input  logic [ADDR_W-1:0] req_pc,
    output logic              ic_req_valid,
    input  logic              ic_req_ready,
    output logic [GID_W-1:0]  ic_req_gid,
    output logic [ADDR_W-1:0] ic_req_addr,
    input  logic              ic_rsp_valid,
    output logic              ic_rsp_ready,
    input  logic [GID_W-1:0]  ic_rsp_gid,
    input  logic [LINE_W-1:0] ic_rsp_line,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [GID_W-1:0]  out_gid,
    output logic [ADDR_W-1:0] out_pc,
    output logic [31:0]       out_instr
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = OFF_W - 2;
    localparam int CNT_W = $clog2(NUM_GRP + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]    pc;     // PC of the request in flight
        logic                 need2;  // waiting for the second half
        logic [FA_HALF_W-1:0] low;    // kept first half
    } grp_t;

    grp_t [NUM_GRP-1:0] grp_q, grp_d;

    // refetch queue
    logic             rf_push, rf_pop, rf_busy;
    logic [GID_W-1:0] rf_head;
    logic [CNT_W-1:0] rf_count;

    // response path
    grp_t             rsp_grp;
    logic [IDX_W-1:0] word_idx;
    logic [31:0]      rsp_word;
    rsp_kind_e        kind;
    logic [31:0]      al_instr;

    assign rsp_grp  = grp_q[ic_rsp_gid];
    // a second fetch reads the next word; the index wraps inside the new line
    assign word_idx = rsp_grp.pc[OFF_W-1:2] + IDX_W'(rsp_grp.need2);

    fa_refetch_fifo #(
        .DEPTH (NUM_GRP),
        .W     (GID_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rf_push),
        .push_data (ic_rsp_gid),
        .pop       (rf_pop),
        .head      (rf_head),
        .count     (rf_count)
    );

    fa_line_word #(
        .LINE_BYTES (LINE_BYTES)
    ) u_word (
        .line (ic_rsp_line),
        .idx  (word_idx),
        .word (rsp_word)
    );

    fa_half_align u_align (
        .pc_hi    (rsp_grp.pc[1]),
        .need2    (rsp_grp.need2),
        .kept_low (rsp_grp.low),
        .word     (rsp_word),
        .kind     (kind),
        .instr    (al_instr)
    );

    always_comb begin
        grp_d   = grp_q;
        rf_push = 1'b0;

        // request side: queued second fetches win
        rf_busy      = (rf_count != '0);
        ic_req_valid = rf_busy | req_valid;
        ic_req_gid   = rf_busy ? rf_head : req_gid;
        ic_req_addr  = rf_busy ? ({grp_q[rf_head].pc[ADDR_W-1:2], 2'b00} + ADDR_W'(4))
                               : {req_pc[ADDR_W-1:2], 2'b00};
        req_ready    = ~rf_busy & ic_req_ready;
        rf_pop       = rf_busy & ic_req_ready;

        if (req_valid && req_ready) begin
            grp_d[req_gid].pc    = req_pc;
            grp_d[req_gid].need2 = 1'b0;
            grp_d[req_gid].low   = '0;
        end

        // response side
        ic_rsp_ready = out_ready;
        out_valid    = ic_rsp_valid && (kind != RK_HEAD);
        out_gid      = ic_rsp_gid;
        out_pc       = rsp_grp.pc;
        out_instr    = al_instr;

        if (ic_rsp_valid && out_ready) begin
            unique case (kind)
                RK_HEAD: begin
                    grp_d[ic_rsp_gid].need2 = 1'b1;
                    grp_d[ic_rsp_gid].low   = rsp_word[31:16];
                    rf_push                 = 1'b1;
                end
                RK_TAIL: begin
                    grp_d[ic_rsp_gid].need2 = 1'b0;
                    grp_d[ic_rsp_gid].low   = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
    parameter int ADDR_W  = 32,
    parameter int NUM_GRP = 4,
    localparam int CNT_W  = $clog2(NUM_GRP + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-3:0] req_pc_hi,
    input logic              ic_req_valid,
    input logic [ADDR_W-1:0] ic_req_addr,
    input logic              ic_rsp_valid,
    input logic              out_valid,
    input logic [CNT_W-1:0]  rf_count
);

    // R1
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ic_req_valid |-> (ic_req_addr[1:0] == 2'b00));

    // R1
    new_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rf_count == '0) |-> (ic_req_addr[ADDR_W-1:2] == req_pc_hi));

    // R2
    refetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_count != '0) |-> (ic_req_valid && !req_ready));

    // R9
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_count <= CNT_W'(NUM_GRP));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_count == '0 && !req_valid) |-> !ic_req_valid);

    // R10
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ic_rsp_valid);

endmodule

bind fetch_aligner fa_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_GRP (NUM_GRP)
) u_fa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_pc_hi    (req_pc[ADDR_W-1:2]),
    .ic_req_valid (ic_req_valid),
    .ic_req_addr  (ic_req_addr),
    .ic_rsp_valid (ic_rsp_valid),
    .out_valid    (out_valid),
    .rf_count     (rf_count)
);

// File: tb/tb_fetch_aligner.sv
`timescale 1ns/1ps
module tb_fetch_aligner;

    localparam int NG = 4;
    localparam int AW = 32;
    localparam int LB = 16;
    localparam int LW = LB * 8;
    localparam int GW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic          req_valid = 1'b0, req_ready;
    logic [GW-1:0] req_gid = '0;
    logic [AW-1:0] req_pc = '0;
    logic          ic_req_valid, ic_req_ready = 1'b1;
    logic [GW-1:0] ic_req_gid;
    logic [AW-1:0] ic_req_addr;
    logic          ic_rsp_valid = 1'b0, ic_rsp_ready;
    logic [GW-1:0] ic_rsp_gid = '0;
    logic [LW-1:0] ic_rsp_line = '0;
    logic          out_valid, out_ready = 1'b1;
    logic [GW-1:0] out_gid;
    logic [AW-1:0] out_pc;
    logic [31:0]   out_instr;

    fetch_aligner #(.NUM_GRP(NG), .ADDR_W(AW), .LINE_BYTES(LB)) dut (.*);

    logic [15:0]   mem_h [0:127];
    logic [AW-1:0] iss_addr [$];
    logic [GW-1:0] iss_gid  [$];
    logic [AW-1:0] pnd_addr [$];
    logic [GW-1:0] pnd_gid  [$];
    logic [31:0]   o_instr  [$];
    logic [GW-1:0] o_gid    [$];
    logic [AW-1:0] o_pc     [$];

    int errors = 0;
    int checks = 0;

    // cache model: response visible one cycle after acceptance
    always @(posedge clk) begin
        if (rst_n) begin
            if (ic_req_valid && ic_req_ready) begin
                iss_addr.push_back(ic_req_addr);
                iss_gid.push_back(ic_req_gid);
                pnd_addr.push_back(ic_req_addr);
                pnd_gid.push_back(ic_req_gid);
            end
            if (ic_rsp_valid && ic_rsp_ready) begin
                void'(pnd_addr.pop_front());
                void'(pnd_gid.pop_front());
            end
            if (out_valid && out_ready) begin
                o_instr.push_back(out_instr);
                o_gid.push_back(out_gid);
                o_pc.push_back(out_pc);
            end
        end
    end

    function automatic logic [LW-1:0] make_line(input logic [AW-1:0] addr);
        logic [LW-1:0] l;
        for (int k = 0; k < LB/2; k++) l[k*16 +: 16] = mem_h[int'(addr[7:4]) * 8 + k];
        return l;
    endfunction

    always @(negedge clk) begin
        if (pnd_addr.size() > 0) begin
            ic_rsp_valid = 1'b1;
            ic_rsp_gid   = pnd_gid[0];
            ic_rsp_line  = make_line(pnd_addr[0]);
        end else begin
            ic_rsp_valid = 1'b0;
        end
    end

    function automatic logic [31:0] exp_instr(input logic [AW-1:0] pc);
        int i = int'(pc[7:1]);
        if (mem_h[i][1:0] != 2'b11) return {16'h0, mem_h[i]};
        return {mem_h[i+1], mem_h[i]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_c(input int pc, input logic [15:0] v);
        mem_h[pc/2] = {v[15:2], 2'b10};
    endtask

    task automatic put_w(input int pc, input logic [31:0] v);
        mem_h[pc/2]     = {v[15:2], 2'b11};
        mem_h[pc/2 + 1] = v[31:16];
    endtask

    task automatic clear_logs();
        iss_addr.delete(); iss_gid.delete();
        o_instr.delete(); o_gid.delete(); o_pc.delete();
    endtask

    // returns at the accepting edge; req_valid is left high
    task automatic send_req(input int gid, input int pc);
        @(negedge clk);
        req_valid = 1'b1;
        req_gid   = GW'(gid);
        req_pc    = AW'(pc);
        @(posedge clk);
        while (!req_ready) @(posedge clk);
    endtask

    task automatic drop_req();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_outs(input int n);
        int t = 0;
        while (o_instr.size() < n && t < 60) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic expect_out(input int gid, input int pc, input string tag);
        logic [31:0] e;
        e = exp_instr(AW'(pc));
        if (o_instr.size() == 0) begin
            chk(1'b0, {tag, " missing output"}, 32'h0, e);
        end else begin
            logic [31:0]   ai = o_instr.pop_front();
            logic [GW-1:0] ag = o_gid.pop_front();
            logic [AW-1:0] ap = o_pc.pop_front();
            chk(ai == e, {tag, " instr"}, ai, e);
            chk(ag == GW'(gid) && ap == AW'(pc), {tag, " R11 gid/pc tag"}, {ag, ap[29:0]}, {GW'(gid), 30'(pc)});
        end
    endtask

    task automatic expect_issue(input int addr, input int gid, input string tag);
        if (iss_addr.size() == 0) begin
            chk(1'b0, {tag, " missing cache request"}, 32'h0, 32'(addr));
        end else begin
            logic [AW-1:0] a = iss_addr.pop_front();
            logic [GW-1:0] g = iss_gid.pop_front();
            chk(a == AW'(addr) && g == GW'(gid), {tag, " cache request"}, a, 32'(addr));
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ic_req_valid == 1'b0, "R8 no request after reset", 32'(ic_req_valid), 32'h0);
        chk(out_valid == 1'b0, "R8 no output after reset", 32'(out_valid), 32'h0);
        chk(req_ready == 1'b1, "R8 queue empty, new request takeable", 32'(req_ready), 32'h1);
    endtask

    task automatic test_short();
        clear_logs();
        put_c(8'h00, 16'h4a51);
        put_c(8'h02, 16'h9c3d);
        send_req(0, 8'h00); drop_req();
        wait_outs(1);
        expect_out(0, 8'h00, "R4 lower half");
        expect_issue(8'h00, 0, "R1 aligned pc");
        send_req(1, 8'h02); drop_req();
        wait_outs(1);
        expect_out(1, 8'h02, "R4 upper half");
        expect_issue(8'h00, 1, "R1 pc bit1 cleared");
    endtask

    task automatic test_full();
        clear_logs();
        put_w(8'h04, 32'h12345677);
        put_w(8'h18, 32'hcafe0f13);
        put_w(8'h0c, 32'h0badf00f);
        send_req(2, 8'h04); drop_req();
        wait_outs(1);
        expect_out(2, 8'h04, "R5 aligned word");
        send_req(3, 8'h18); drop_req();
        wait_outs(1);
        expect_out(3, 8'h18, "R3 offset 8");
        send_req(0, 8'h0c); drop_req();
        wait_outs(1);
        expect_out(0, 8'h0c, "R3 offset 12");
        expect_issue(8'h04, 2, "R1 word request");
        expect_issue(8'h18, 3, "R1 word request");
        expect_issue(8'h0c, 0, "R1 word request");
    endtask

    task automatic test_split();
        clear_logs();
        put_w(8'h22, 32'h76543217);
        send_req(0, 8'h22); drop_req();
        wait_outs(1);
        repeat (4) @(negedge clk);
        chk(o_instr.size() == 1, "R6 one output for split instr", 32'(o_instr.size()), 32'h1);
        chk(iss_addr.size() == 2, "R6 second fetch queued", 32'(iss_addr.size()), 32'h2);
        expect_out(0, 8'h22, "R7 joined halves");
        expect_issue(8'h20, 0, "R1 first fetch");
        expect_issue(8'h24, 0, "R2 second fetch");
    endtask

    task automatic test_cross();
        clear_logs();
        put_w(8'h2e, 32'hbeef1003);
        send_req(1, 8'h2e); drop_req();
        wait_outs(1);
        expect_out(1, 8'h2e, "R3 R7 split across lines");
        expect_issue(8'h2c, 1, "R1 first fetch");
        expect_issue(8'h30, 1, "R2 next line fetch");
    endtask

    task automatic test_priority();
        clear_logs();
        put_w(8'h46, 32'h55aa66bb);
        put_c(8'h50, 16'h1234);
        send_req(0, 8'h46);
        @(negedge clk);
        ic_req_ready = 1'b0;
        req_gid = GW'(1);
        req_pc  = AW'(8'h50);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R2 new request held back", 32'(req_ready), 32'h0);
        chk(ic_req_valid && ic_req_addr == AW'(8'h48), "R2 refetch shown", ic_req_addr, 32'h48);
        ic_req_ready = 1'b1;
        @(posedge clk);
        while (!req_ready) @(posedge clk);
        drop_req();
        wait_outs(2);
        expect_out(0, 8'h46, "R7 priority split");
        expect_out(1, 8'h50, "R4 priority short");
        expect_issue(8'h44, 0, "R1 first");
        expect_issue(8'h48, 0, "R2 refetch before new");
        expect_issue(8'h50, 1, "R2 new after refetch");
    endtask

    task automatic test_order();
        clear_logs();
        put_w(8'h5a, 32'h01020307);
        put_w(8'h66, 32'h0a0b0c0f);
        send_req(2, 8'h5a);
        send_req(3, 8'h66);
        @(negedge clk);
        req_valid = 1'b0;
        ic_req_ready = 1'b0;
        repeat (4) @(negedge clk);
        ic_req_ready = 1'b1;
        wait_outs(2);
        expect_out(2, 8'h5a, "R9 first queued");
        expect_out(3, 8'h66, "R9 second queued");
        expect_issue(8'h58, 2, "R1 first");
        expect_issue(8'h64, 3, "R1 second");
        expect_issue(8'h5c, 2, "R9 oldest refetch first");
        expect_issue(8'h68, 3, "R9 younger refetch second");
    endtask

    task automatic test_backpressure();
        logic [31:0] held;
        clear_logs();
        put_c(8'h70, 16'h7e5d);
        out_ready = 1'b0;
        send_req(1, 8'h70); drop_req();
        @(negedge clk);
        chk(out_valid == 1'b1, "R10 result presented", 32'(out_valid), 32'h1);
        chk(ic_rsp_ready == 1'b0, "R10 response not consumed", 32'(ic_rsp_ready), 32'h0);
        held = out_instr;
        repeat (2) @(negedge clk);
        chk(out_valid && out_instr == held, "R10 result stable", out_instr, held);
        chk(o_instr.size() == 0, "R10 nothing taken while stalled", 32'(o_instr.size()), 32'h0);
        out_ready = 1'b1;
        wait_outs(1);
        repeat (3) @(negedge clk);
        chk(o_instr.size() == 1, "R10 exactly one result", 32'(o_instr.size()), 32'h1);
        expect_out(1, 8'h70, "R10 released");
    endtask

    task automatic test_mix();
        int pcs [10];
        int pc = 8'h00;
        clear_logs();
        for (int k = 0; k < 10; k++) begin
            pcs[k] = pc;
            if (k % 3 == 1) begin
                put_w(pc, 32'h9e3779b9 ^ (k * 32'h01010101));
                pc += 4;
            end else begin
                put_c(pc, 16'h6c8d ^ 16'(k * 16'h0403));
                pc += 2;
            end
        end
        for (int k = 0; k < 10; k++) begin
            send_req(k % NG, pcs[k]); drop_req();
            wait_outs(1);
            expect_out(k % NG, pcs[k], "R4 R5 R7 mixed stream");
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem_h[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_short();
        test_full();
        test_split();
        test_cross();
        test_priority();
        test_order();
        test_backpressure();
        test_mix();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule